// File: doc/BRIEF.md
# Synchronized Word Capture with Parity Retry

This block takes an 8-bit data word and a strobe that both arrive with no timing relation to the system clock. Both pass through a chain of flip-flops clocked on the rising edge before any logic sees them. A rising edge of the synchronized strobe starts a capture. The capture register stores the settled word together with an even-parity bit. That bit is computed one synchronizer stage upstream, so it describes the word one cycle newer than the data bits beside it.

In the next cycle the block recomputes parity from the stored data and compares it with the stored bit. If they agree, the word goes to the output with a one-cycle valid pulse. If they disagree, the word moved while it was being sampled, and the block captures again. After a set number of failed attempts it raises a sticky give-up flag and goes back to waiting for a strobe. A saturating counter records every failed comparison. The control states are assigned a Gray code, so each transition flips only one state bit.

Top module: `parity_retry_capture`

## Requirements
- R1: Word and strobe each pass through SYNC_STAGES (default 2) flip-flops on the rising clock edge. With the inputs set before rising edge 1 and held, word_valid is low after edge 4 and high after edge 5.
- R2: A capture starts only on a low-to-high change of the synchronized strobe while the block is idle. A strobe held high for many cycles yields exactly one accepted word.
- R3: The capture register holds 9 bits: 8 data bits from the last synchronizer stage, and one even-parity bit (XOR of all 8 bits) of the word in the stage before it. A word held steady is always accepted on the first attempt, and the mismatch counter does not change.
- R4: When the recomputed parity equals the stored bit, word_out takes the stored data and word_valid is high for exactly one cycle.
- R5: On a parity disagreement the block captures the input again, and mismatch_count goes up by one, saturating at its maximum.
- R6: After MAX_TRIES (default 3) failed attempts on one strobe, give_up goes high and stays high until reset. No valid pulse is produced, and the block returns to idle, where later strobes are captured normally.
- R7: word_out changes only in the cycle word_valid is high, and it holds its value between accepted captures, including across attempts that are abandoned.
- R8: The state codes are idle 00, capture 01, check 11 and done 10. A retry goes straight from check to capture (11 to 01), so one retry moves the valid pulse from after edge 5 to after edge 7.
- R9: The synchronous active-high reset clears the synchronizer stages, the state, the attempt counter, give_up, mismatch_count, word_valid and word_out (to 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| async_word | input | DATA_W | Data word from the unrelated clock domain |
| async_strobe | input | 1 | Capture request from the unrelated clock domain |
| word_valid | output | 1 | One-cycle pulse marking an accepted word |
| word_out | output | DATA_W | Last accepted word, held until the next acceptance |
| give_up | output | 1 | Sticky flag: retry limit reached |
| mismatch_count | output | CNT_W | Saturating count of parity disagreements |

## Verification
The assertions assume that reset is held for at least one rising edge before any check is meaningful. They also assume the strobe does not pulse again while a capture is in progress. The stimulus keeps the strobe apart from every capture by at least ten idle cycles, and it changes inputs only on falling edges. A disagreement between the stored parity and the stored data is provoked on purpose. The stimulus changes the word to one of opposite parity at a chosen cycle, or toggles it every cycle between two words of opposite parity, so that the two synchronizer taps differ during a capture.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_CAPTURE = 2'b01,
    ST_CHECK   = 2'b11,
    ST_DONE    = 2'b10
  } cap_state_t;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_prev,
  output logic [W-1:0] q_last
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_prev = stg[STAGES-2];
  assign q_last = stg[STAGES-1];
endmodule

// File: rtl/parity_capture.sv
module parity_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word_in,
  input  logic [W-1:0] par_src,
  output logic [W-1:0] cap_word,
  output logic         par_ok
);
  localparam int REG_W = W + 1;

  logic [REG_W-1:0] cap_reg;

  always_ff @(posedge clk) begin
    if (rst)       cap_reg <= '0;
    else if (load) cap_reg <= {^par_src, word_in};
  end

  assign cap_word = cap_reg[W-1:0];
  assign par_ok   = ((^cap_reg[W-1:0]) == cap_reg[W]);
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int W         = 8,
  parameter int MAX_TRIES = 3,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             par_ok,
  input  logic [W-1:0]     cap_word,
  output logic             load,
  output logic             out_valid,
  output logic [W-1:0]     out_data,
  output logic             give_up,
  output logic [CNT_W-1:0] mism_count
);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [TRY_W-1:0] TRY_LIMIT = TRY_W'(MAX_TRIES);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;

  cap_state_t       state;
  logic [TRY_W-1:0] tries;

  assign load = (state == ST_CAPTURE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      tries      <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      give_up    <= 1'b0;
      mism_count <= '0;
    end else begin
      out_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_CAPTURE;
            tries <= '0;
          end
        end
        ST_CAPTURE: begin
          tries <= tries + 1'b1;
          state <= ST_CHECK;
        end
        ST_CHECK: begin
          if (par_ok) begin
            out_data  <= cap_word;
            out_valid <= 1'b1;
            state     <= ST_DONE;
          end else begin
            if (mism_count != CNT_MAX) mism_count <= mism_count + 1'b1;
            if (tries >= TRY_LIMIT) begin
              give_up <= 1'b1;
              state   <= ST_DONE;
            end else begin
              state <= ST_CAPTURE;
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: one state bit flips per transition
  a_r8_gray_step: assert property (@(posedge clk) disable iff (rst)
    $countones(state ^ $past(state)) <= 1);

  // R4: valid lasts a single cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R6: attempt count never passes the limit; give_up is sticky
  a_r6_try_bound: assert property (@(posedge clk) disable iff (rst)
    tries <= TRY_LIMIT);
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(give_up) |-> give_up);
  a_r6_no_valid_on_abort: assert property (@(posedge clk) disable iff (rst)
    $rose(give_up) |-> !out_valid);

  // R7: output word moves only with a valid pulse
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (out_data != $past(out_data)) |-> out_valid);
endmodule

// File: rtl/parity_retry_capture.sv
module parity_retry_capture #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_TRIES   = 3,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] async_word,
  input  logic              async_strobe,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_out,
  output logic              give_up,
  output logic [CNT_W-1:0]  mismatch_count
);
  localparam int STB_STAGES = SYNC_STAGES + 1;

  logic [DATA_W-1:0] w_prev, w_last, cap_word;
  logic              s_prev, s_last, start, load, par_ok;

  sync_chain #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_wsync (
    .clk(clk), .rst(rst), .d(async_word), .q_prev(w_prev), .q_last(w_last)
  );

  sync_chain #(.W(1), .STAGES(STB_STAGES)) u_ssync (
    .clk(clk), .rst(rst), .d(async_strobe), .q_prev(s_prev), .q_last(s_last)
  );

  assign start = s_prev & ~s_last;

  parity_capture #(.W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .load(load), .word_in(w_last), .par_src(w_prev),
    .cap_word(cap_word), .par_ok(par_ok)
  );

  cap_ctrl #(.W(DATA_W), .MAX_TRIES(MAX_TRIES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .par_ok(par_ok), .cap_word(cap_word),
    .load(load), .out_valid(word_valid), .out_data(word_out),
    .give_up(give_up), .mism_count(mismatch_count)
  );

  // R3: an accepted word always carries matching even parity at the output
  a_r3_accept_needs_match: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(par_ok));
endmodule

// File: tb/sim_parity_retry_capture.sv
`timescale 1ns/1ps
module sim_parity_retry_capture;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] async_word;
  logic       async_strobe;
  logic       word_valid;
  logic [7:0] word_out;
  logic       give_up;
  logic [7:0] mismatch_count;

  int tests = 0;
  int fails = 0;
  int valid_seen = 0;
  bit prev_valid = 1'b0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  parity_retry_capture u0 (
    .clk(clk), .rst(rst), .async_word(async_word), .async_strobe(async_strobe),
    .word_valid(word_valid), .word_out(word_out), .give_up(give_up),
    .mismatch_count(mismatch_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop on each valid pulse
  always @(negedge clk) begin
    if (!rst && word_valid) begin
      valid_seen++;
      check("R4 single-cycle valid", {31'd0, prev_valid}, 32'd0);
      if (exp_q.size() == 0) begin
        check("R2 unexpected valid", 32'd1, 32'd0);
      end else begin
        check("R4 word_out", {24'd0, word_out}, {24'd0, exp_q.pop_front()});
      end
    end
    prev_valid = word_valid && !rst;
  end

  task automatic capture_word(input logic [7:0] w);
    @(negedge clk);
    async_word = w;
    async_strobe = 1'b1;
    exp_q.push_back(w);
    repeat (3) @(negedge clk);
    async_strobe = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    async_word = 8'h00;
    async_strobe = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 valid", {31'd0, word_valid}, 32'd0);
    check("R9 word_out", {24'd0, word_out}, 32'd0);
    check("R9 give_up", {31'd0, give_up}, 32'd0);
    check("R9 count", {24'd0, mismatch_count}, 32'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 latency, R2 strobe held high, R3 steady word accepted
    async_word = 8'hA5;
    async_strobe = 1'b1;
    exp_q.push_back(8'hA5);
    repeat (4) @(negedge clk);
    check("R1 no valid after edge 4", {31'd0, word_valid}, 32'd0);
    @(negedge clk);
    check("R1 valid after edge 5", {31'd0, word_valid}, 32'd1);
    repeat (12) @(negedge clk);
    async_strobe = 1'b0;
    repeat (8) @(negedge clk);
    check("R2 one word for held strobe", valid_seen, 32'd1);
    check("R3 steady word no mismatch", {24'd0, mismatch_count}, 32'd0);

    // R5/R8: word changes to opposite parity during first capture
    async_word = 8'h3C;
    async_strobe = 1'b1;
    exp_q.push_back(8'h37);
    repeat (2) @(negedge clk);
    async_word = 8'h37;
    repeat (4) @(negedge clk);
    check("R8 no valid after edge 6", {31'd0, word_valid}, 32'd0);
    @(negedge clk);
    check("R8 retry valid after edge 7", {31'd0, word_valid}, 32'd1);
    check("R5 count after one retry", {24'd0, mismatch_count}, 32'd1);
    async_strobe = 1'b0;
    repeat (10) @(negedge clk);
    check("R7 word held", {24'd0, word_out}, 32'h37);
    check("R6 give_up still low", {31'd0, give_up}, 32'd0);

    // R6: word toggles every cycle, all attempts fail
    for (int i = 0; i < 24; i++) begin
      async_word = (i % 2 == 0) ? 8'h01 : 8'h03;
      if (i == 0) async_strobe = 1'b1;
      if (i == 5) async_strobe = 1'b0;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
    check("R6 give_up raised", {31'd0, give_up}, 32'd1);
    check("R5 count after three failures", {24'd0, mismatch_count}, 32'd4);
    check("R6 no valid on abort", valid_seen, 32'd2);
    check("R7 word held over abort", {24'd0, word_out}, 32'h37);

    // R6: later strobe still works, give_up sticky
    capture_word(8'hC3);
    check("R6 give_up sticky", {31'd0, give_up}, 32'd1);
    check("R6 capture after abort", {24'd0, word_out}, 32'hC3);
    check("R2 total accepted", valid_seen, 32'd3);
    check("R4 scoreboard drained", exp_q.size(), 32'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule